// File: doc/BRIEF.md
# Processor Data Address Generator

This block turns a decoded addressing-mode code plus the processor's pointer registers, instruction constants and a short offset into one memory address per access. A data-space address is 23 bits wide: a 7-bit upper part that selects a main page, and a 16-bit lower part. An I/O-space address is 16 bits wide and is returned in the low bits of the same output. A flag tells the bus which of the two spaces the address belongs to.

The modes are absolute addressing (a 16-bit constant under the page-high register, a full 23-bit constant, or a 16-bit I/O port constant), direct addressing against either the data page pointer or the stack pointer, and auxiliary-register indirect addressing. Indirect addressing can leave the pointer alone, step it up by one after the access, or step it down by one after the access. Stepping modes send the new pointer value out on a write-back port, so the register file can store it. The result is computed combinationally. A parameter can add one register stage at the output.

Top module: `dag_top`

## Requirements
- R1: Mode code 0 (absolute 16-bit) gives address = {page_hi_i, k16_i} in data space.
- R2: Mode code 1 (absolute 23-bit) gives address = k23_i in data space.
- R3: Mode code 2 (I/O absolute) raises io_space_o. It gives address bits [15:0] = k16_i and bits [22:16] = 0.
- R4: Mode code 3 with cpl_sp_i = 0 gives address = {page_hi_i, dp_i + ofs_i}. The 7-bit offset is zero-extended.
- R5: Mode code 3 with cpl_sp_i = 1 gives address = {stack_hi_i, sp_i + ofs_i}. The 7-bit offset is zero-extended and ranges from 0 to 127.
- R6: The 16-bit lower-part sum in direct modes wraps modulo 2^16 and never changes the upper 7 bits.
- R7: Mode code 4 (plain indirect) gives address = {page_hi_i, AR[ar_sel_i]}, with ar_wb_en_o = 0. AR n occupies bits [16n+15:16n] of ar_bank_i.
- R8: Mode codes 5 (post-increment) and 6 (post-decrement) form the address from the unmodified AR[ar_sel_i]. They raise ar_wb_en_o, drive ar_wb_sel_o = ar_sel_i, and drive ar_wb_val_o = AR ± 1 modulo 2^16.
- R9: Mode code 7 is undefined. It raises mode_err_o and drives the address to 0, with io_space_o = 0 and ar_wb_en_o = 0.
- R10: With REG_OUT = 1 (the default), every output reflects the inputs present at the previous rising clock edge. An active-low reset clears all outputs to 0.
- R11: io_space_o is 0 for every mode except code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Decoded addressing-mode code |
| cpl_sp_i | input | 1 | Direct-mode base select: 0 = page pointer, 1 = stack pointer |
| page_hi_i | input | 7 | Main data page (upper address bits) |
| stack_hi_i | input | 7 | Stack page (upper address bits) |
| dp_i | input | 16 | Data page pointer |
| sp_i | input | 16 | Stack pointer |
| ar_bank_i | input | 128 | Eight 16-bit auxiliary registers, AR0 in the low bits |
| ar_sel_i | input | 3 | Auxiliary register index |
| k16_i | input | 16 | 16-bit instruction constant |
| k23_i | input | 23 | 23-bit instruction constant |
| ofs_i | input | 7 | Unsigned direct-mode offset |
| addr_o | output | 23 | Generated address |
| io_space_o | output | 1 | 1 = I/O space, 0 = data space |
| mode_err_o | output | 1 | Undefined mode code seen |
| ar_wb_en_o | output | 1 | Write-back strobe for the selected AR |
| ar_wb_sel_o | output | 3 | Index of the AR to write back |
| ar_wb_val_o | output | 16 | Post-modified AR value |

## Verification
The corner cases are the direct-mode sums that overflow 16 bits, with both the page pointer and the stack pointer. A design that carries the overflow into the page bits would return the next page up. Increments of 0xFFFF and decrements of 0 test the write-back wrap. A design that emits the modified pointer as the address instead of the old one fails those same vectors. I/O accesses are run with a non-zero page register, which catches page bits leaking into port addresses. The undefined code is checked against a stale address and against a spurious write-back. The latency check confirms that new inputs do not reach the outputs before the clock edge.

// File: rtl/dag_pkg.sv
package dag_pkg;

    parameter int DAG_HI_W   = 7;
    parameter int DAG_LO_W   = 16;
    parameter int DAG_OFS_W  = 7;
    parameter int DAG_NUM_AR = 8;

    localparam int DAG_ADDR_W = DAG_HI_W + DAG_LO_W;
    localparam int DAG_SEL_W  = $clog2(DAG_NUM_AR);

    typedef enum logic [2:0] {
        MODE_ABS16  = 3'd0,
        MODE_ABS23  = 3'd1,
        MODE_IO_ABS = 3'd2,
        MODE_DIRECT = 3'd3,
        MODE_AR     = 3'd4,
        MODE_AR_INC = 3'd5,
        MODE_AR_DEC = 3'd6
    } dag_mode_e;

    typedef struct packed {
        logic [DAG_ADDR_W-1:0] addr;
        logic                  io_space;
        logic                  mode_err;
        logic                  wb_en;
        logic [DAG_SEL_W-1:0]  wb_sel;
        logic [DAG_LO_W-1:0]   wb_val;
    } dag_out_t;

endpackage

// File: rtl/dag_direct_sum.sv
module dag_direct_sum
    import dag_pkg::*;
(
    input  logic                  use_stack,
    input  logic [DAG_HI_W-1:0]   page_hi,
    input  logic [DAG_HI_W-1:0]   stack_hi,
    input  logic [DAG_LO_W-1:0]   dp,
    input  logic [DAG_LO_W-1:0]   sp,
    input  logic [DAG_OFS_W-1:0]  ofs,
    output logic [DAG_ADDR_W-1:0] addr
);

    logic [DAG_LO_W-1:0] base_lo;
    logic [DAG_HI_W-1:0] base_hi;
    logic [DAG_LO_W-1:0] ofs_ext;
    logic [DAG_LO_W-1:0] sum_lo;

    always_comb begin
        base_lo = use_stack ? sp       : dp;
        base_hi = use_stack ? stack_hi : page_hi;
        ofs_ext = {{(DAG_LO_W-DAG_OFS_W){1'b0}}, ofs};
        // lower part is a closed 16-bit ring: the carry out is dropped
        sum_lo  = base_lo + ofs_ext;
        addr    = {base_hi, sum_lo};
    end

endmodule

// File: rtl/dag_ar_unit.sv
module dag_ar_unit
    import dag_pkg::*;
(
    input  logic [DAG_NUM_AR*DAG_LO_W-1:0] ar_bank,
    input  logic [DAG_SEL_W-1:0]           sel,
    input  logic                           step_up,
    input  logic                           step_dn,
    output logic [DAG_LO_W-1:0]            cur,
    output logic                           wb_en,
    output logic [DAG_LO_W-1:0]            wb_val
);

    logic [DAG_LO_W-1:0] ar_arr [DAG_NUM_AR];

    for (genvar g = 0; g < DAG_NUM_AR; g++) begin : g_unpack
        assign ar_arr[g] = ar_bank[g*DAG_LO_W +: DAG_LO_W];
    end

    always_comb begin
        cur    = ar_arr[sel];
        wb_en  = step_up | step_dn;
        wb_val = cur;
        if (step_up) begin
            wb_val = cur + DAG_LO_W'(1);
        end else if (step_dn) begin
            wb_val = cur - DAG_LO_W'(1);
        end
    end

endmodule

// File: rtl/dag_top.sv
module dag_top
    import dag_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     mode_i,
    input  logic                           cpl_sp_i,
    input  logic [DAG_HI_W-1:0]            page_hi_i,
    input  logic [DAG_HI_W-1:0]            stack_hi_i,
    input  logic [DAG_LO_W-1:0]            dp_i,
    input  logic [DAG_LO_W-1:0]            sp_i,
    input  logic [DAG_NUM_AR*DAG_LO_W-1:0] ar_bank_i,
    input  logic [DAG_SEL_W-1:0]           ar_sel_i,
    input  logic [DAG_LO_W-1:0]            k16_i,
    input  logic [DAG_ADDR_W-1:0]          k23_i,
    input  logic [DAG_OFS_W-1:0]           ofs_i,
    output logic [DAG_ADDR_W-1:0]          addr_o,
    output logic                           io_space_o,
    output logic                           mode_err_o,
    output logic                           ar_wb_en_o,
    output logic [DAG_SEL_W-1:0]           ar_wb_sel_o,
    output logic [DAG_LO_W-1:0]            ar_wb_val_o
);

    dag_mode_e mode;
    assign mode = dag_mode_e'(mode_i);

    logic [DAG_ADDR_W-1:0] direct_addr;
    logic [DAG_LO_W-1:0]   ptr_cur;
    logic                  ptr_wb_en;
    logic [DAG_LO_W-1:0]   ptr_wb_val;
    logic                  step_up;
    logic                  step_dn;

    assign step_up = (mode_i == MODE_AR_INC);
    assign step_dn = (mode_i == MODE_AR_DEC);

    dag_direct_sum i_direct (
        .use_stack (cpl_sp_i),
        .page_hi   (page_hi_i),
        .stack_hi  (stack_hi_i),
        .dp        (dp_i),
        .sp        (sp_i),
        .ofs       (ofs_i),
        .addr      (direct_addr)
    );

    dag_ar_unit i_ar (
        .ar_bank (ar_bank_i),
        .sel     (ar_sel_i),
        .step_up (step_up),
        .step_dn (step_dn),
        .cur     (ptr_cur),
        .wb_en   (ptr_wb_en),
        .wb_val  (ptr_wb_val)
    );

    dag_out_t out_d;
    dag_out_t out_q;

    always_comb begin
        out_d = '0;
        case (mode)
            MODE_ABS16:  out_d.addr = {page_hi_i, k16_i};
            MODE_ABS23:  out_d.addr = k23_i;
            MODE_IO_ABS: begin
                out_d.addr     = {{DAG_HI_W{1'b0}}, k16_i};
                out_d.io_space = 1'b1;
            end
            MODE_DIRECT: out_d.addr = direct_addr;
            MODE_AR, MODE_AR_INC, MODE_AR_DEC: begin
                // address always built from the pointer before any step
                out_d.addr   = {page_hi_i, ptr_cur};
                out_d.wb_en  = ptr_wb_en;
                out_d.wb_sel = ptr_wb_en ? ar_sel_i : '0;
                out_d.wb_val = ptr_wb_en ? ptr_wb_val : '0;
            end
            default:     out_d.mode_err = 1'b1;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign addr_o      = out_q.addr;
    assign io_space_o  = out_q.io_space;
    assign mode_err_o  = out_q.mode_err;
    assign ar_wb_en_o  = out_q.wb_en;
    assign ar_wb_sel_o = out_q.wb_sel;
    assign ar_wb_val_o = out_q.wb_val;

    // R8: a write-back value is always one step away from the pointer read
    a_r8_wb_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |-> ((ptr_wb_val == DAG_LO_W'(ptr_cur + DAG_LO_W'(1))) ||
                       (ptr_wb_val == DAG_LO_W'(ptr_cur - DAG_LO_W'(1)))));

    // R8: the pointer unit only steps for the two post-modify codes
    a_r8_wb_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |-> (mode_i == 3'd5 || mode_i == 3'd6));

    // R9: an undefined code leaves no address and no write-back behind
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> (addr_o == '0 && !ar_wb_en_o && !io_space_o));

    // R3: port addresses never carry page bits
    a_r3_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        io_space_o |-> (addr_o[DAG_ADDR_W-1:DAG_LO_W] == '0));

    // R11: I/O accesses never come with a pointer write-back
    a_r11_io_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        io_space_o |-> !ar_wb_en_o);

    // R6: a direct-mode sum keeps the selected page
    a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        direct_addr[DAG_ADDR_W-1:DAG_LO_W] == (cpl_sp_i ? stack_hi_i : page_hi_i));

endmodule

// File: tb/test_dag_top.sv
module test_dag_top;
    import dag_pkg::*;

    typedef struct packed {
        logic [2:0]  mode;
        logic        cpl;
        logic [6:0]  ph;
        logic [6:0]  sh;
        logic [15:0] dp;
        logic [15:0] sp;
        logic [2:0]  sel;
        logic [15:0] arval;
        logic [15:0] k16;
        logic [22:0] k23;
        logic [6:0]  ofs;
        logic [22:0] e_addr;
        logic        e_io;
        logic        e_err;
        logic        e_wb;
        logic [2:0]  e_sel;
        logic [15:0] e_wbv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R1: page-high over 16-bit constant
        '{default:'0, mode:3'd0, ph:7'h55, k16:16'hBEEF, e_addr:23'h55BEEF, req:8'd1},
        // R2: full 23-bit constant
        '{default:'0, mode:3'd1, ph:7'h11, k23:23'h7ABCDE, e_addr:23'h7ABCDE, req:8'd2},
        // R3: I/O port, page bits must not leak
        '{default:'0, mode:3'd2, ph:7'h7F, k16:16'h1234, e_addr:23'h001234, e_io:1'b1, req:8'd3},
        // R4: page-relative direct
        '{default:'0, mode:3'd3, ph:7'h12, dp:16'h0400, ofs:7'h05, e_addr:23'h120405, req:8'd4},
        // R5: stack-relative direct, max offset
        '{default:'0, mode:3'd3, cpl:1'b1, ph:7'h12, sh:7'h21, sp:16'h8000, ofs:7'h7F,
          e_addr:23'h21807F, req:8'd5},
        // R6: page-pointer sum wraps, page stays
        '{default:'0, mode:3'd3, ph:7'h01, dp:16'hFFF0, ofs:7'h20, e_addr:23'h010010, req:8'd6},
        // R6: stack-pointer sum wraps, stack page stays
        '{default:'0, mode:3'd3, cpl:1'b1, sh:7'h7F, sp:16'hFFFF, ofs:7'h01, e_addr:23'h7F0000, req:8'd6},
        // R7: plain indirect, no write-back
        '{default:'0, mode:3'd4, ph:7'h02, sel:3'd3, arval:16'hA5A5, e_addr:23'h02A5A5, req:8'd7},
        // R8: post-increment wraps, address uses old value
        '{default:'0, mode:3'd5, ph:7'h03, sel:3'd6, arval:16'hFFFF, e_addr:23'h03FFFF,
          e_wb:1'b1, e_sel:3'd6, e_wbv:16'h0000, req:8'd8},
        // R8: post-decrement wraps
        '{default:'0, mode:3'd6, ph:7'h00, sel:3'd0, arval:16'h0000, e_addr:23'h000000,
          e_wb:1'b1, e_sel:3'd0, e_wbv:16'hFFFF, req:8'd8},
        // R9: undefined code
        '{default:'0, mode:3'd7, ph:7'h33, k16:16'h4444, k23:23'h123456, e_err:1'b1, req:8'd9},
        // R1: zero page, all-ones constant
        '{default:'0, mode:3'd0, ph:7'h00, k16:16'hFFFF, e_addr:23'h00FFFF, req:8'd1}
    };

    logic                  clk;
    logic                  rst_n;
    logic [2:0]            mode_i;
    logic                  cpl_sp_i;
    logic [6:0]            page_hi_i;
    logic [6:0]            stack_hi_i;
    logic [15:0]           dp_i;
    logic [15:0]           sp_i;
    logic [7:0][15:0]      ar_arr;
    logic [127:0]          ar_bank_i;
    logic [2:0]            ar_sel_i;
    logic [15:0]           k16_i;
    logic [22:0]           k23_i;
    logic [6:0]            ofs_i;
    logic [22:0]           addr_o;
    logic                  io_space_o;
    logic                  mode_err_o;
    logic                  ar_wb_en_o;
    logic [2:0]            ar_wb_sel_o;
    logic [15:0]           ar_wb_val_o;

    assign ar_bank_i = ar_arr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    dag_top i_dag_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .cpl_sp_i    (cpl_sp_i),
        .page_hi_i   (page_hi_i),
        .stack_hi_i  (stack_hi_i),
        .dp_i        (dp_i),
        .sp_i        (sp_i),
        .ar_bank_i   (ar_bank_i),
        .ar_sel_i    (ar_sel_i),
        .k16_i       (k16_i),
        .k23_i       (k23_i),
        .ofs_i       (ofs_i),
        .addr_o      (addr_o),
        .io_space_o  (io_space_o),
        .mode_err_o  (mode_err_o),
        .ar_wb_en_o  (ar_wb_en_o),
        .ar_wb_sel_o (ar_wb_sel_o),
        .ar_wb_val_o (ar_wb_val_o)
    );

    initial clk = 1'b0;
    always #4ns clk = ~clk;

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            report();
        end
    end

    task automatic drive(input vec_t v);
        mode_i     = v.mode;
        cpl_sp_i   = v.cpl;
        page_hi_i  = v.ph;
        stack_hi_i = v.sh;
        dp_i       = v.dp;
        sp_i       = v.sp;
        ar_sel_i   = v.sel;
        k16_i      = v.k16;
        k23_i      = v.k23;
        ofs_i      = v.ofs;
        for (int k = 0; k < 8; k++) ar_arr[k] = 16'h1000 + 16'(k * 16'h0111);
        ar_arr[v.sel] = v.arval;
    endtask

    task automatic check(input vec_t v, input string tag);
        logic [45:0] act, exp;
        act = {addr_o, io_space_o, mode_err_o, ar_wb_en_o, ar_wb_sel_o, ar_wb_val_o};
        exp = {v.e_addr, v.e_io, v.e_err, v.e_wb, v.e_sel, v.e_wbv};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual addr=%h io=%b err=%b wb=%b sel=%0d val=%h expected addr=%h io=%b err=%b wb=%b sel=%0d val=%h",
                     v.req, tag, addr_o, io_space_o, mode_err_o, ar_wb_en_o, ar_wb_sel_o, ar_wb_val_o,
                     v.e_addr, v.e_io, v.e_err, v.e_wb, v.e_sel, v.e_wbv);
        end
    endtask

    initial begin
        vec_t zero_v;
        zero_v = '{default:'0, req:8'd10};
        rst_n = 1'b0;
        drive(VEC[0]);
        repeat (2) @(negedge clk);
        // R10: reset state
        check(zero_v, "reset clears outputs");
        rst_n = 1'b1;

        // table walk: drive at a falling edge, result registered at the next rise
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(VEC[i], "vector");
        end

        // R10: new inputs must not reach the outputs before the clock edge
        drive(VEC[1]);
        @(negedge clk);
        drive(VEC[8]);
        #1ns;
        check(VEC[1], "latency hold");
        @(negedge clk);
        check(VEC[8], "latency update");

        // R11: stack direct mode stays in data space even with I/O-like constant
        drive(VEC[4]);
        k16_i = 16'hFFFF;
        @(negedge clk);
        check(VEC[4], "data space flag");

        // R9: back-to-back undefined after a write-back clears stale state
        drive(VEC[9]);
        @(negedge clk);
        drive(VEC[10]);
        @(negedge clk);
        check(VEC[10], "error after write-back");

        // R10: asynchronous reset mid-run
        drive(VEC[8]);
        @(negedge clk);
        rst_n = 1'b0;
        #1ns;
        check(zero_v, "async reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;

        report();
    end

endmodule